// File: doc/BRIEF.md
# SD Card Single-Block Read Sequencer (SPI Mode)

This block performs a complete single-block read from an SD card running in SPI mode. It does not drive the SPI pins. Instead it talks to a byte-exchange engine through a request/acknowledge pair. For each byte it places an outgoing byte on a bus and pulses a request. The engine later answers with an acknowledge and the byte it clocked in from the card. Only one exchange is ever in flight.

A start pulse carries in a 32-bit block number. The sequencer then runs the whole transaction without software help:
- it polls until the card reports ready;
- it sends the six-byte read command;
- it polls for the one-byte reply, with a bounded number of attempts;
- it hunts for the start-of-data token;
- it streams the 512 payload bytes out, each with a strobe and its index in the block;
- it exchanges and discards the two checksum bytes.

It finishes with a one-cycle done pulse. If the card rejects the command or never answers, it finishes with a one-cycle error pulse and a reply code instead. A consumer can write the payload straight into a 512-byte buffer using the index.

Top module: `sdrd_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `xchg_req_o`, `rd_valid_o`, `busy_o`, `done_o` and `err_o` are 0, `err_code_o` is 0x00 and `xchg_tx_o` is 0xFF.
- R2: After an accepted start, the block sends 0xFF exchanges until the card returns 0xFF. No command byte is sent before that 0xFF reply.
- R3: The command frame is six bytes in this order: 0x51 (0x40 OR read index 17), the block number bytes from bits 31:24 down to bits 7:0, then 0xFF. The block number is the one captured at the accepted start.
- R4: After the frame, the block sends 0xFF exchanges until a non-0xFF byte returns; that byte is the reply. If 8000 consecutive 0xFF bytes return, it stops and raises the error with code 0xFF, after exactly 8000 reply-poll exchanges.
- R5: A reply other than 0x00 raises `err_o` for one cycle with `err_code_o` equal to that reply. The block then issues no data strobe and no further exchange. `err_code_o` changes only in a cycle where `err_o` is high.
- R6: After a 0x00 reply, the block sends 0xFF exchanges until 0xFE returns. Bytes that arrive before 0xFE are never presented on the data output.
- R7: The 512 bytes that follow 0xFE each produce one `rd_valid_o` pulse. On each pulse, `rd_byte_o` is the received byte and `rd_idx_o` counts 0 to 511 in order. Each of these exchanges sends 0xFF.
- R8: After the last data byte, two more 0xFF exchanges are made and their returned bytes are not presented. Then `done_o` pulses for one cycle and no further exchange is issued.
- R9: `busy_o` rises in the cycle after an accepted start and stays high until the cycle in which `done_o` or `err_o` is high, where it is low. A start pulse while busy is ignored, including its block number.
- R10: At most one exchange is outstanding. After a request pulse, no new request appears until the acknowledge for it has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that begins a read; accepted only when idle |
| blk_num_i | input | 32 | Block number, sampled with an accepted start |
| xchg_req_o | output | 1 | One-cycle request for a byte exchange |
| xchg_tx_o | output | 8 | Byte to send, valid with the request |
| xchg_ack_i | input | 1 | Exchange finished; `xchg_rx_i` holds the returned byte |
| xchg_rx_i | input | 8 | Byte returned by the card |
| rd_valid_o | output | 1 | Payload byte strobe |
| rd_byte_o | output | 8 | Payload byte |
| rd_idx_o | output | 9 | Position of the payload byte within the block |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle pulse: block read completed |
| err_o | output | 1 | One-cycle pulse: read aborted |
| err_code_o | output | 8 | Reply byte that caused the last abort (0xFF for timeout) |

## Verification
The bench drives the block with a card model that is deliberately slow to become ready and that returns junk (non-0xFE, non-0xFF bytes) before the data token. A sequencer that left the ready wait early, or that treated any non-0xFF byte as the token, would either garble the frame or stream junk as payload. The reply poll is pushed to its full 8000-attempt limit. A poll counter off by one shows up as a wrong exchange count at the timeout error. A nonzero reply must stop the transaction cold; a design that carried on would issue extra exchanges or data strobes. A second start with a different block number arrives mid-transaction: a design that re-armed, or that read the block number live, would send the wrong frame or finish twice. Acknowledges arrive zero to two cycles after each request, which exposes any request issued while one is still outstanding.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

  localparam logic [7:0] FILL_B   = 8'hFF;  // idle / dummy byte on the line
  localparam logic [7:0] TOKEN_B  = 8'hFE;  // start-of-data token
  localparam logic [7:0] REPLY_OK = 8'h00;  // accepted-command reply
  localparam logic [5:0] CMD_READ = 6'd17;  // single-block read index
  localparam logic [1:0] CMD_PFX  = 2'b01;  // start + transmission bits

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_CMD,
    ST_POLL,
    ST_TOKEN,
    ST_DATA,
    ST_CRC
  } phase_t;

endpackage

// File: rtl/sdrd_rst_sync.sv
module sdrd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sdrd_frame.sv
module sdrd_frame
  import sdrd_pkg::*;
#(
  parameter int BN_BYTES = 4,
  localparam int FLEN  = BN_BYTES + 2,
  localparam int SEL_W = $clog2(FLEN),
  localparam int BN_W  = 8 * BN_BYTES
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [BN_W-1:0]  bn_i,
  output logic [7:0]       byte_o
);

  logic [7:0] slot [FLEN];

  assign slot[0] = {CMD_PFX, CMD_READ};

  // Block number goes out most significant byte first.
  for (genvar g = 0; g < BN_BYTES; g++) begin : g_bn
    assign slot[1+g] = bn_i[BN_W-1-8*g -: 8];
  end

  assign slot[FLEN-1] = FILL_B;  // checksum slot, unused in SPI mode

  always_comb begin
    byte_o = FILL_B;
    for (int k = 0; k < FLEN; k++) begin
      if (sel_i == SEL_W'(k)) byte_o = slot[k];
    end
  end

endmodule

// File: rtl/sdrd_port.sv
module sdrd_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue_i,
  input  logic [7:0] issue_byte_i,
  input  logic       ack_i,
  input  logic [7:0] rx_i,
  output logic       req_o,
  output logic [7:0] tx_o,
  output logic       got_o,
  output logic [7:0] got_byte_o
);

  logic       req_q;
  logic [7:0] tx_q;
  logic       pend_q;
  logic       pend_d;

  // An acknowledge only counts while a request is outstanding.
  assign got_o      = ack_i & pend_q;
  assign got_byte_o = rx_i;

  always_comb begin
    pend_d = pend_q;
    if (got_o)   pend_d = 1'b0;
    if (issue_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      tx_q   <= 8'hFF;
      pend_q <= 1'b0;
    end else begin
      req_q  <= issue_i;
      pend_q <= pend_d;
      if (issue_i) tx_q <= issue_byte_i;
    end
  end

  assign req_o = req_q;
  assign tx_o  = tx_q;

endmodule

// File: rtl/sdrd_ctl.sv
module sdrd_ctl
  import sdrd_pkg::*;
#(
  parameter int FLEN       = 6,
  parameter int POLL_LIMIT = 8000,
  parameter int BLK_BYTES  = 512,
  parameter int CRC_BYTES  = 2,
  localparam int SEL_W   = $clog2(FLEN),
  localparam int IDX_W   = $clog2(BLK_BYTES),
  localparam int CNT_MAX = (POLL_LIMIT > BLK_BYTES) ? POLL_LIMIT : BLK_BYTES,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             got_i,
  input  logic [7:0]       rx_i,
  output logic             accept_o,
  output logic             issue_o,
  output logic             frame_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             valid_o,
  output logic [7:0]       byte_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       code_o,
  output logic             busy_o
);

  phase_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             val_q, val_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [7:0]       code_q, code_d;
  logic [7:0]       byte_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    val_d    = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    code_d   = code_q;
    accept_o = 1'b0;
    issue_o  = 1'b0;
    frame_o  = 1'b0;
    sel_o    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          issue_o  = 1'b1;
          st_d     = ST_READY;
        end
      end
      ST_READY: begin
        if (got_i) begin
          issue_o = 1'b1;
          if (rx_i == FILL_B) begin
            st_d    = ST_CMD;
            cnt_d   = '0;
            frame_o = 1'b1;
            sel_o   = '0;
          end
        end
      end
      ST_CMD: begin
        if (got_i) begin
          issue_o = 1'b1;
          if (cnt_q == CNT_W'(FLEN - 1)) begin
            st_d  = ST_POLL;
            cnt_d = '0;
          end else begin
            cnt_d   = cnt_q + CNT_W'(1);
            frame_o = 1'b1;
            sel_o   = cnt_q[SEL_W-1:0] + SEL_W'(1);
          end
        end
      end
      ST_POLL: begin
        if (got_i) begin
          if (rx_i != FILL_B) begin
            if (rx_i == REPLY_OK) begin
              issue_o = 1'b1;
              st_d    = ST_TOKEN;
            end else begin
              err_d  = 1'b1;
              code_d = rx_i;
              st_d   = ST_IDLE;
            end
          end else if (cnt_q == CNT_W'(POLL_LIMIT - 1)) begin
            err_d  = 1'b1;
            code_d = FILL_B;
            st_d   = ST_IDLE;
          end else begin
            issue_o = 1'b1;
            cnt_d   = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_TOKEN: begin
        if (got_i) begin
          issue_o = 1'b1;
          if (rx_i == TOKEN_B) begin
            st_d  = ST_DATA;
            cnt_d = '0;
          end
        end
      end
      ST_DATA: begin
        if (got_i) begin
          issue_o = 1'b1;
          val_d   = 1'b1;
          if (cnt_q == CNT_W'(BLK_BYTES - 1)) begin
            st_d  = ST_CRC;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_CRC: begin
        if (got_i) begin
          if (cnt_q == CNT_W'(CRC_BYTES - 1)) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            issue_o = 1'b1;
            cnt_d   = cnt_q + CNT_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      val_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= 8'h00;
      byte_q <= 8'h00;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      val_q  <= val_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (err_d) code_q <= code_d;
      if (val_d) begin
        byte_q <= rx_i;
        idx_q  <= cnt_q[IDX_W-1:0];
      end
    end
  end

  assign valid_o = val_q;
  assign byte_o  = byte_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign code_o  = code_q;
  assign busy_o  = (st_q != ST_IDLE);

endmodule

// File: rtl/sdrd_seq.sv
module sdrd_seq
  import sdrd_pkg::*;
#(
  parameter int BN_BYTES   = 4,
  parameter int POLL_LIMIT = 8000,
  parameter int BLK_BYTES  = 512,
  parameter int CRC_BYTES  = 2,
  localparam int BN_W  = 8 * BN_BYTES,
  localparam int IDX_W = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BN_W-1:0]  blk_num_i,
  output logic             xchg_req_o,
  output logic [7:0]       xchg_tx_o,
  input  logic             xchg_ack_i,
  input  logic [7:0]       xchg_rx_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_byte_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       err_code_o
);

  localparam int FLEN  = BN_BYTES + 2;
  localparam int SEL_W = $clog2(FLEN);

  logic             rst_i_n;
  logic             accept;
  logic             issue;
  logic             use_frame;
  logic [SEL_W-1:0] sel;
  logic [7:0]       frm_byte;
  logic [7:0]       issue_byte;
  logic             got;
  logic [7:0]       got_byte;
  logic [BN_W-1:0]  bn_q;

  sdrd_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Block number is frozen at acceptance; later input changes are ignored.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    bn_q <= '0;
    else if (accept) bn_q <= blk_num_i;
  end

  sdrd_frame #(.BN_BYTES(BN_BYTES)) i_frame (
    .sel_i  (sel),
    .bn_i   (bn_q),
    .byte_o (frm_byte)
  );

  assign issue_byte = use_frame ? frm_byte : FILL_B;

  sdrd_port i_port (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .issue_i      (issue),
    .issue_byte_i (issue_byte),
    .ack_i        (xchg_ack_i),
    .rx_i         (xchg_rx_i),
    .req_o        (xchg_req_o),
    .tx_o         (xchg_tx_o),
    .got_o        (got),
    .got_byte_o   (got_byte)
  );

  sdrd_ctl #(
    .FLEN       (FLEN),
    .POLL_LIMIT (POLL_LIMIT),
    .BLK_BYTES  (BLK_BYTES),
    .CRC_BYTES  (CRC_BYTES)
  ) i_ctl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start_i  (start_i),
    .got_i    (got),
    .rx_i     (got_byte),
    .accept_o (accept),
    .issue_o  (issue),
    .frame_o  (use_frame),
    .sel_o    (sel),
    .valid_o  (rd_valid_o),
    .byte_o   (rd_byte_o),
    .idx_o    (rd_idx_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .code_o   (err_code_o),
    .busy_o   (busy_o)
  );

endmodule

// File: rtl/sdrd_seq_chk.sv
module sdrd_seq_chk #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xchg_req_o,
  input logic             xchg_ack_i,
  input logic             rd_valid_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [7:0]       err_code_o
);

  logic             outst_q;
  logic [IDX_W:0]   vcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      vcnt_q  <= '0;
    end else begin
      outst_q <= (outst_q | xchg_req_o) & ~xchg_ack_i;
      if (done_o || err_o) vcnt_q <= '0;
      else if (rd_valid_o) vcnt_q <= vcnt_q + 1'b1;
    end
  end

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !xchg_req_o);

  p_idx_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_idx_o == vcnt_q[IDX_W-1:0]));

  p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!xchg_req_o && !rd_valid_o));

  p_end_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o);

  p_busy_falls_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || err_o));

  p_done_err_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_code_moves_with_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_code_o) |-> err_o);

endmodule

bind sdrd_seq sdrd_seq_chk #(.IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xchg_req_o (xchg_req_o),
  .xchg_ack_i (xchg_ack_i),
  .rd_valid_o (rd_valid_o),
  .rd_idx_o   (rd_idx_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .err_code_o (err_code_o)
);

// File: tb/test_sdrd_seq.sv
`timescale 1ns/1ps
module test_sdrd_seq;

  localparam int POLL_N = 8000;
  localparam int BLK_N  = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] blk_num_i;
  logic        xchg_req_o;
  logic [7:0]  xchg_tx_o;
  logic        xchg_ack_i;
  logic [7:0]  xchg_rx_i;
  logic        rd_valid_o;
  logic [7:0]  rd_byte_o;
  logic [8:0]  rd_idx_o;
  logic        busy_o;
  logic        done_o;
  logic        err_o;
  logic [7:0]  err_code_o;

  always #4 clk = ~clk;  // 125 MHz

  sdrd_seq i_sdrd_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .blk_num_i  (blk_num_i),
    .xchg_req_o (xchg_req_o),
    .xchg_tx_o  (xchg_tx_o),
    .xchg_ack_i (xchg_ack_i),
    .xchg_rx_i  (xchg_rx_i),
    .rd_valid_o (rd_valid_o),
    .rd_byte_o  (rd_byte_o),
    .rd_idx_o   (rd_idx_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .err_code_o (err_code_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // card model configuration
  int       cfg_busy;
  int       cfg_poll;
  bit       cfg_reply_en;
  logic [7:0] cfg_reply;
  int       cfg_token;
  int       cfg_seed;

  // observations
  int         nreq;
  int         pre_bad, post_bad, outst_bad;
  logic [7:0] frm_log [6];
  int         done_cnt, err_cnt, vcnt, data_bad, busy_bad;
  logic [7:0] last_code;
  bit         prev_busy;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + cfg_seed) & 8'hFF);
  endfunction

  function automatic logic [7:0] card_reply(input int n);
    int m;
    if (n < cfg_busy) return 8'h00;
    if (n == cfg_busy) return 8'hFF;
    m = n - cfg_busy - 1;
    if (m < 6) return 8'hFF;
    m = m - 6;
    if (!cfg_reply_en) return 8'hFF;
    if (m < cfg_poll) return 8'hFF;
    if (m == cfg_poll) return cfg_reply;
    m = m - cfg_poll - 1;
    if (m < cfg_token) return 8'h3C;
    if (m == cfg_token) return 8'hFE;
    m = m - cfg_token - 1;
    if (m < BLK_N) return pat(m);
    m = m - BLK_N;
    if (m == 0) return 8'hA5;
    return 8'h5A;
  endfunction

  task automatic log_tx(input int n, input logic [7:0] tx);
    int fs;
    fs = cfg_busy + 1;
    if (n < fs) begin
      if (tx != 8'hFF) pre_bad++;
    end else if (n < fs + 6) begin
      frm_log[n-fs] = tx;
    end else if (tx != 8'hFF) begin
      post_bad++;
    end
  endtask

  // card / exchange engine model
  initial begin
    xchg_ack_i = 1'b0;
    xchg_rx_i  = 8'h00;
    forever begin
      @(negedge clk);
      while (xchg_req_o === 1'b1) begin
        int n;
        n = nreq;
        nreq++;
        log_tx(n, xchg_tx_o);
        repeat (n % 3) begin
          @(negedge clk);
          if (xchg_req_o) outst_bad++;
        end
        xchg_ack_i = 1'b1;
        xchg_rx_i  = card_reply(n);
        @(negedge clk);
        xchg_ack_i = 1'b0;
        xchg_rx_i  = 8'h00;
      end
    end
  end

  // output monitor
  initial begin
    prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rd_valid_o) begin
          if (rd_idx_o != 9'(vcnt) || rd_byte_o != pat(vcnt)) data_bad++;
          vcnt++;
        end
        if (done_o) done_cnt++;
        if (err_o) begin
          err_cnt++;
          last_code = err_code_o;
        end
        if ((done_o || err_o) && busy_o) busy_bad++;
        if (prev_busy && !busy_o && !(done_o || err_o)) busy_bad++;
        prev_busy = busy_o;
      end
    end
  end

  task automatic clear_obs();
    nreq = 0; pre_bad = 0; post_bad = 0; outst_bad = 0;
    done_cnt = 0; err_cnt = 0; vcnt = 0; data_bad = 0; busy_bad = 0;
    last_code = 8'h00;
    for (int k = 0; k < 6; k++) frm_log[k] = 8'h00;
  endtask

  task automatic launch(input logic [31:0] bn);
    clear_obs();
    @(negedge clk);
    blk_num_i = bn;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
  endtask

  task automatic wait_end();
    while (done_cnt + err_cnt == 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic check_frame(input logic [31:0] bn);
    logic [7:0] exp [6];
    exp[0] = 8'h51; exp[1] = bn[31:24]; exp[2] = bn[23:16];
    exp[3] = bn[15:8]; exp[4] = bn[7:0]; exp[5] = 8'hFF;
    for (int k = 0; k < 6; k++)
      chk(frm_log[k] == exp[k], "R3 frame byte", int'(frm_log[k]), int'(exp[k]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; blk_num_i = '0;
    clear_obs();
    repeat (4) @(negedge clk);
    chk(!xchg_req_o && !rd_valid_o && !busy_o && !done_o && !err_o, "R1 outputs in reset",
        {xchg_req_o, rd_valid_o, busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(err_code_o == 8'h00, "R1 err code", int'(err_code_o), 0);
    chk(xchg_tx_o == 8'hFF, "R1 tx idle", int'(xchg_tx_o), 8'hFF);
    chk(!xchg_req_o && !busy_o && nreq == 0, "R1 no activity", nreq, 0);
  endtask

  task automatic t_read(input logic [31:0] bn, input int busy, input int poll,
                        input int token, input int seed);
    int exp_req;
    cfg_busy = busy; cfg_poll = poll; cfg_reply_en = 1'b1; cfg_reply = 8'h00;
    cfg_token = token; cfg_seed = seed;
    launch(bn);
    wait_end();
    exp_req = busy + 1 + 6 + poll + 1 + token + 1 + BLK_N + 2;
    chk(pre_bad == 0, "R2 no command before ready", pre_bad, 0);
    check_frame(bn);
    chk(post_bad == 0, "R4 R6 R7 fill bytes after frame", post_bad, 0);
    chk(vcnt == BLK_N, "R7 strobe count", vcnt, BLK_N);
    chk(data_bad == 0, "R7 data and index", data_bad, 0);
    chk(done_cnt == 1 && err_cnt == 0, "R8 single done", done_cnt, 1);
    chk(nreq == exp_req, "R8 R6 exchange count", nreq, exp_req);
    chk(busy_bad == 0 && !busy_o, "R9 busy envelope", busy_bad, 0);
    chk(outst_bad == 0, "R10 one outstanding", outst_bad, 0);
  endtask

  task automatic t_reply_err(input logic [7:0] code);
    int exp_req;
    cfg_busy = 2; cfg_poll = 3; cfg_reply_en = 1'b1; cfg_reply = code;
    cfg_token = 0; cfg_seed = 1;
    launch(32'h0000_0042);
    wait_end();
    exp_req = 2 + 1 + 6 + 3 + 1;
    chk(err_cnt == 1 && done_cnt == 0, "R5 error pulse", err_cnt, 1);
    chk(last_code == code, "R5 error code", int'(last_code), int'(code));
    chk(err_code_o == code, "R5 code held", int'(err_code_o), int'(code));
    chk(vcnt == 0, "R5 no data", vcnt, 0);
    chk(nreq == exp_req, "R5 stops exchanging", nreq, exp_req);
    chk(busy_bad == 0 && !busy_o, "R9 busy on error", busy_bad, 0);
  endtask

  task automatic t_timeout();
    int exp_req;
    cfg_busy = 1; cfg_poll = 0; cfg_reply_en = 1'b0; cfg_reply = 8'h00;
    cfg_token = 0; cfg_seed = 2;
    launch(32'hDEAD_BEEF);
    wait_end();
    exp_req = 1 + 1 + 6 + POLL_N;
    chk(err_cnt == 1 && done_cnt == 0, "R4 timeout error", err_cnt, 1);
    chk(last_code == 8'hFF, "R4 timeout code", int'(last_code), 8'hFF);
    chk(nreq == exp_req, "R4 poll attempts", nreq, exp_req);
    chk(outst_bad == 0, "R10 one outstanding", outst_bad, 0);
    check_frame(32'hDEAD_BEEF);
  endtask

  task automatic t_restart_ignored();
    int exp_req;
    cfg_busy = 6; cfg_poll = 1; cfg_reply_en = 1'b1; cfg_reply = 8'h00;
    cfg_token = 2; cfg_seed = 77;
    launch(32'hA1B2_C3D4);
    repeat (2) @(negedge clk);
    blk_num_i = 32'h0F0E_0D0C;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
    wait_end();
    exp_req = 6 + 1 + 6 + 1 + 1 + 2 + 1 + BLK_N + 2;
    check_frame(32'hA1B2_C3D4);
    chk(done_cnt == 1 && err_cnt == 0, "R9 second start ignored", done_cnt, 1);
    chk(nreq == exp_req, "R9 single transaction", nreq, exp_req);
    chk(data_bad == 0 && vcnt == BLK_N, "R7 data after restart attempt", data_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0x%0h expected=0x%0h", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_read(32'h1234_5678, 3, 2, 4, 5);
    t_read(32'h8000_0001, 0, 0, 0, 200);
    t_reply_err(8'h05);
    t_reply_err(8'h01);
    t_timeout();
    t_restart_ignored();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule